// File: doc/BRIEF.md
# Row-Hit Tracking DRAM Command Queue

This block is a first-in first-out queue that sits between the address translation stage and the DRAM command sequencer. Every accepted command carries a bank, row and column address and a read/write direction. As each new command arrives, its bank and row are compared with those of the command accepted just before it. The result is written back into that earlier entry as two hit bits. The earlier entry therefore learns whether the access following it reuses its bank, or its open row.

When an entry leaves the queue it carries its bank-hit and row-hit bits and an auto-precharge flag. Auto-precharge is asserted only when no row hit was recorded. A row that the next command will read or write therefore stays open, and every other row is closed at once to shorten the next row miss.

The head entry is held back until a successor exists, because until then its hit bits are not final. A flush input lets the last entry leave without waiting. Reordering and DRAM timing are left to the sequencer.

Top module: `dram_cmd_hit_fifo`

## Requirements
- R1: After reset the queue reports empty=1, full=0 and popAvail=0, and the address of the previous command is forgotten, so the first command pushed after reset never marks any entry.
- R2: Commands leave in the order they were accepted, with bank, row, column and write bit unchanged.
- R3: If a pushed command has the same bank and the same row as the previously accepted command, and that command is still queued, the earlier entry leaves with popBankHit=1, popRowHit=1 and popAutoPre=0.
- R4: If the pushed command has the same bank but a different row, the earlier entry leaves with popBankHit=1, popRowHit=0 and popAutoPre=1.
- R5: If the pushed command targets a different bank, the earlier entry keeps popBankHit=0, popRowHit=0 and popAutoPre=1.
- R6: popAvail is 1 only when at least two entries are queued, or when one or more entries are queued and flush is 1. A popReady without popAvail removes nothing.
- R7: With flush=1 a lone entry may leave. It carries the hit bits recorded up to that point, which are 0 with auto-precharge set if nothing followed it.
- R8: full=1 when DEPTH entries are queued. A push while full is discarded: nothing is stored, no entry is marked, and the previous-address register keeps the last accepted command.
- R9: A pop request while empty has no effect: the queue stays empty, and the next push is delivered intact.
- R10: A push and a pop in the same cycle both take effect. The head leaves with the flags it holds, and the entry behind the new command receives that command's hit bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| pushValid | input | 1 | Offer a command for queuing |
| pushBank | input | BANK_W | Bank of the offered command |
| pushRow | input | ROW_W | Row of the offered command |
| pushCol | input | COL_W | Column of the offered command |
| pushWrite | input | 1 | 1 = write, 0 = read |
| full | output | 1 | Queue holds DEPTH entries |
| popReady | input | 1 | Sequencer takes the head entry when popAvail is 1 |
| flush | input | 1 | Allow the head to leave without a successor |
| empty | output | 1 | Queue holds no entry |
| popAvail | output | 1 | Head entry may be taken this cycle |
| popBank | output | BANK_W | Bank of the head entry |
| popRow | output | ROW_W | Row of the head entry |
| popCol | output | COL_W | Column of the head entry |
| popWrite | output | 1 | Direction of the head entry |
| popBankHit | output | 1 | Next command uses the same bank |
| popRowHit | output | 1 | Next command uses the same bank and row |
| popAutoPre | output | 1 | Issue the head with auto-precharge |

## Verification
The two functions that can coincide are removing the head and marking the entry behind a newly arriving command. In one cycle a pop takes the head while a push sets the hit bits of an older entry. The bench queues two commands to the same row, then raises popReady together with a push to the same bank but a new row. It judges the head that leaves on its row-hit flags, and the surviving entry, when it later reaches the head, on a bank-only hit with auto-precharge. A flush that empties a one-entry queue is also exercised, so a mark is never lost or moved onto a freed slot.

// File: rtl/hit_fifo_pkg.sv
package hit_fifo_pkg;
  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic wrEn;    // store incoming command at write index
    logic rdEn;    // head leaves the queue
    logic markEn;  // entry before the new one is still resident
  } hit_fifo_strobe_t;
endpackage

// File: rtl/hit_fifo_ctrl.sv
module hit_fifo_ctrl
  import hit_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic             popReady,
  input  logic             flush,
  output hit_fifo_strobe_t strobe,
  output logic [PTR_W-1:0] wrIdx,
  output logic [PTR_W-1:0] rdIdx,
  output logic [PTR_W-1:0] markIdx,
  output logic             full,
  output logic             empty,
  output logic             popAvail
);
  logic [PTR_W:0]   count;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  always_comb begin
    full     = (count == (PTR_W+1)'(DEPTH));
    empty    = (count == '0);
    popAvail = !empty && ((count > (PTR_W+1)'(1)) || flush);
    strobe.wrEn   = pushValid && !full;
    strobe.rdEn   = popReady && popAvail;
    // Skip the mark when the only resident entry is leaving now.
    strobe.markEn = strobe.wrEn && !empty &&
                    !(strobe.rdEn && (count == (PTR_W+1)'(1)));
    wrIdx   = wrPtr;
    rdIdx   = rdPtr;
    markIdx = wrPtr - PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.wrEn) wrPtr <= wrPtr + PTR_W'(1);
      if (strobe.rdEn) rdPtr <= rdPtr + PTR_W'(1);
      case ({strobe.wrEn, strobe.rdEn})
        2'b10:   count <= count + (PTR_W+1)'(1);
        2'b01:   count <= count - (PTR_W+1)'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/hit_fifo_data.sv
module hit_fifo_data
  import hit_fifo_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  hit_fifo_strobe_t  strobe,
  input  logic [PTR_W-1:0]  wrIdx,
  input  logic [PTR_W-1:0]  rdIdx,
  input  logic [PTR_W-1:0]  markIdx,
  input  logic [BANK_W-1:0] pushBank,
  input  logic [ROW_W-1:0]  pushRow,
  input  logic [COL_W-1:0]  pushCol,
  input  logic              pushWrite,
  output logic [BANK_W-1:0] popBank,
  output logic [ROW_W-1:0]  popRow,
  output logic [COL_W-1:0]  popCol,
  output logic              popWrite,
  output logic              popBankHit,
  output logic              popRowHit,
  output logic              popAutoPre
);
  logic [BANK_W-1:0] bankMem [DEPTH];
  logic [ROW_W-1:0]  rowMem  [DEPTH];
  logic [COL_W-1:0]  colMem  [DEPTH];
  logic              wrMem   [DEPTH];
  logic              bHitMem [DEPTH];
  logic              rHitMem [DEPTH];

  logic [BANK_W-1:0] prevBank;
  logic [ROW_W-1:0]  prevRow;
  logic              prevValid;
  logic              sameBank;
  logic              sameRow;

  assign sameBank = prevValid && (pushBank == prevBank);
  assign sameRow  = sameBank && (pushRow == prevRow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBank  <= '0;
      prevRow   <= '0;
      prevValid <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        bankMem[i] <= '0;
        rowMem[i]  <= '0;
        colMem[i]  <= '0;
        wrMem[i]   <= 1'b0;
        bHitMem[i] <= 1'b0;
        rHitMem[i] <= 1'b0;
      end
    end else begin
      if (strobe.rdEn) begin
        bHitMem[rdIdx] <= 1'b0;
        rHitMem[rdIdx] <= 1'b0;
      end
      if (strobe.markEn) begin
        if (sameBank) bHitMem[markIdx] <= 1'b1;
        if (sameRow)  rHitMem[markIdx] <= 1'b1;
      end
      if (strobe.wrEn) begin
        bankMem[wrIdx] <= pushBank;
        rowMem[wrIdx]  <= pushRow;
        colMem[wrIdx]  <= pushCol;
        wrMem[wrIdx]   <= pushWrite;
        bHitMem[wrIdx] <= 1'b0;
        rHitMem[wrIdx] <= 1'b0;
        prevBank  <= pushBank;
        prevRow   <= pushRow;
        prevValid <= 1'b1;
      end
    end
  end

  always_comb begin
    popBank    = bankMem[rdIdx];
    popRow     = rowMem[rdIdx];
    popCol     = colMem[rdIdx];
    popWrite   = wrMem[rdIdx];
    popBankHit = bHitMem[rdIdx];
    popRowHit  = rHitMem[rdIdx];
    popAutoPre = !rHitMem[rdIdx];
  end
endmodule

// File: rtl/dram_cmd_hit_fifo.sv
module dram_cmd_hit_fifo
  import hit_fifo_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [BANK_W-1:0] pushBank,
  input  logic [ROW_W-1:0]  pushRow,
  input  logic [COL_W-1:0]  pushCol,
  input  logic              pushWrite,
  output logic              full,
  input  logic              popReady,
  input  logic              flush,
  output logic              empty,
  output logic              popAvail,
  output logic [BANK_W-1:0] popBank,
  output logic [ROW_W-1:0]  popRow,
  output logic [COL_W-1:0]  popCol,
  output logic              popWrite,
  output logic              popBankHit,
  output logic              popRowHit,
  output logic              popAutoPre
);
  localparam int PTR_W = $clog2(DEPTH);

  hit_fifo_strobe_t strobe;
  logic [PTR_W-1:0] wrIdx;
  logic [PTR_W-1:0] rdIdx;
  logic [PTR_W-1:0] markIdx;

  hit_fifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .popReady(popReady),
    .flush(flush), .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .markIdx(markIdx), .full(full), .empty(empty), .popAvail(popAvail)
  );

  hit_fifo_data #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .markIdx(markIdx), .pushBank(pushBank), .pushRow(pushRow),
    .pushCol(pushCol), .pushWrite(pushWrite), .popBank(popBank),
    .popRow(popRow), .popCol(popCol), .popWrite(popWrite),
    .popBankHit(popBankHit), .popRowHit(popRowHit), .popAutoPre(popAutoPre)
  );
endmodule

// File: rtl/hit_fifo_checker.sv
module hit_fifo_checker (
  input logic clk,
  input logic rstN,
  input logic pushValid,
  input logic popReady,
  input logic full,
  input logic empty,
  input logic popAvail,
  input logic popBankHit,
  input logic popRowHit,
  input logic popAutoPre
);
  assert_not_full_and_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));

  assert_empty_blocks_pop_R9: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !popAvail);

  assert_row_implies_bank_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!empty && popRowHit) |-> (popBankHit && !popAutoPre));

  assert_bank_only_precharges_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!empty && popBankHit && !popRowHit) |-> popAutoPre);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (full && pushValid && !(popReady && popAvail)) |=> full);

  assert_head_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!empty && !popAvail) |=> !empty);
endmodule

bind dram_cmd_hit_fifo hit_fifo_checker i_hit_fifo_checker (
  .clk(clk), .rstN(rstN), .pushValid(pushValid), .popReady(popReady),
  .full(full), .empty(empty), .popAvail(popAvail), .popBankHit(popBankHit),
  .popRowHit(popRowHit), .popAutoPre(popAutoPre)
);

// File: tb/test_dram_cmd_hit_fifo.sv
module test_dram_cmd_hit_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int BANK_W = 3;
  localparam int ROW_W = 14;
  localparam int COL_W = 10;
  localparam int NVEC = 6;

  // Stimulus and expected flags: bank, row, col, write, expBankHit, expRowHit
  localparam int VB [NVEC] = '{1, 1, 1, 2, 2, 0};
  localparam int VR [NVEC] = '{5, 5, 9, 9, 9, 5};
  localparam int VC [NVEC] = '{3, 4, 0, 7, 8, 1};
  localparam int VW [NVEC] = '{0, 1, 0, 1, 0, 0};
  localparam int EB [NVEC] = '{1, 1, 0, 1, 0, 0};
  localparam int ER [NVEC] = '{1, 0, 0, 1, 0, 0};

  logic clk = 0;
  logic rstN = 0;
  logic pushValid = 0;
  logic [BANK_W-1:0] pushBank = '0;
  logic [ROW_W-1:0] pushRow = '0;
  logic [COL_W-1:0] pushCol = '0;
  logic pushWrite = 0;
  logic popReady = 0;
  logic flush = 0;
  logic full, empty, popAvail, popWrite, popBankHit, popRowHit, popAutoPre;
  logic [BANK_W-1:0] popBank;
  logic [ROW_W-1:0] popRow;
  logic [COL_W-1:0] popCol;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_cmd_hit_fifo #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) i_dram_cmd_hit_fifo (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushBank(pushBank),
    .pushRow(pushRow), .pushCol(pushCol), .pushWrite(pushWrite), .full(full),
    .popReady(popReady), .flush(flush), .empty(empty), .popAvail(popAvail),
    .popBank(popBank), .popRow(popRow), .popCol(popCol), .popWrite(popWrite),
    .popBankHit(popBankHit), .popRowHit(popRowHit), .popAutoPre(popAutoPre)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Inputs change after a rising edge; outputs are read 1 time unit later.
  task automatic push(int b, int r, int c, int w);
    @(negedge clk);
    pushValid = 1; pushBank = BANK_W'(b); pushRow = ROW_W'(r);
    pushCol = COL_W'(c); pushWrite = w[0];
    @(posedge clk); #1;
    pushValid = 0;
  endtask

  task automatic pop(bit withFlush);
    @(negedge clk);
    popReady = 1; flush = withFlush;
    @(posedge clk); #1;
    popReady = 0; flush = 0;
  endtask

  task automatic headIs(string req, int b, int r, int c, int w, int eb, int er);
    @(negedge clk);
    chk(req, "bank", int'(popBank), b);
    chk(req, "row", int'(popRow), r);
    chk(req, "col", int'(popCol), c);
    chk(req, "write", int'(popWrite), w);
    chk(req, "bankHit", int'(popBankHit), eb);
    chk(req, "rowHit", int'(popRowHit), er);
    chk(req, "autoPre", int'(popAutoPre), er == 0 ? 1 : 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "empty", int'(empty), 1);
    chk("R1", "full", int'(full), 0);
    chk("R1", "popAvail", int'(popAvail), 0);
    rstN = 1;

    // R2..R5 table walk: push all, then drain in order
    for (int i = 0; i < NVEC; i++) push(VB[i], VR[i], VC[i], VW[i]);
    for (int i = 0; i < NVEC; i++) begin
      if (i == NVEC-1) begin
        // R6: a lone entry is held without flush
        @(negedge clk);
        chk("R6", "popAvail lone", int'(popAvail), 0);
        pop(0);
        chk("R6", "empty after held pop", int'(empty), 0);
      end else begin
        @(negedge clk);
        chk("R6", "popAvail", int'(popAvail), 1);
      end
      headIs(EB[i] == 0 ? "R5" : (ER[i] == 1 ? "R3" : "R4"),
             VB[i], VR[i], VC[i], VW[i], EB[i], ER[i]);
      pop(i == NVEC-1);
    end
    chk("R7", "empty after flush", int'(empty), 1);

    // R9: pop on empty has no effect
    pop(1);
    chk("R9", "empty", int'(empty), 1);
    push(3, 77, 12, 1);
    headIs("R9", 3, 77, 12, 1, 0, 0);
    pop(1);

    // R8: fill to full, then a push that would mark the last entry
    for (int i = 0; i < DEPTH; i++) push(i, i + 100, i, i % 2);
    chk("R8", "full", int'(full), 1);
    push(DEPTH-1, DEPTH-1+100, 5, 0);
    for (int i = 0; i < DEPTH; i++) begin
      headIs("R8", i, i + 100, i, i % 2, 0, 0);
      pop(i == DEPTH-1);
    end
    chk("R8", "empty after drain", int'(empty), 1);

    // R7: previous entry gone; new entry's flags come only from its successor
    push(DEPTH-1, DEPTH-1+100, 2, 0);
    push(3, 3, 3, 1);
    headIs("R7", DEPTH-1, DEPTH-1+100, 2, 0, 0, 0);
    pop(0);
    headIs("R7", 3, 3, 3, 1, 0, 0);
    pop(1);

    // R10: simultaneous push and pop
    push(4, 2, 10, 0);
    push(4, 2, 11, 1);
    headIs("R10", 4, 2, 10, 0, 1, 1);
    @(negedge clk);
    popReady = 1; pushValid = 1; pushBank = 3'd4; pushRow = 14'd3;
    pushCol = 10'd12; pushWrite = 0;
    @(posedge clk); #1;
    popReady = 0; pushValid = 0;
    headIs("R10", 4, 2, 11, 1, 1, 0);
    pop(0);
    headIs("R10", 4, 3, 12, 0, 0, 0);
    pop(1);
    chk("R10", "empty at end", int'(empty), 1);

    finishRun();
  end
endmodule